// File: doc/BRIEF.md
# Base-Limit Region Protection Unit

This block guards a 32-bit address space with a set of protection regions. Each region is an inclusive range of 32-byte blocks: a first block taken from its base register and a last block taken from its limit register. Each region also carries an access-permission code, execute-never and privileged-execute-never flags, a shareability field that is only stored, and a 3-bit index into a table of eight 8-bit memory attributes. Software programs the block through a word-addressed register port. That port holds a control word, a region-number word, four base/limit alias pairs that reach a group of four consecutive regions, and two attribute-table words.

The lookup side takes an address together with privileged, write and fetch qualifiers. One cycle later it reports whether the access is permitted, whether exactly one region matched and which one, and the attribute byte that the matched region's index selects. Overlapping hits are always denied. A miss is allowed only for privileged accesses, and only when the default-map control bit is set. With the unit disabled, every access is allowed.

Top module: `region_guard`

## Requirements
- R1: After reset every register reads zero, `rsp_valid` and `rsp_permit` are 0, and with the unit disabled every lookup is permitted with no hit.
- R2: Register word offsets are: 0 control (bit 0 unit enable, bit 1 fault-handler enable, bit 2 privileged default map; other bits read 0), 1 region number (only the low log2(regions) bits are kept), 10 and 11 attribute words. Attribute entry i sits in word 10 + i/4 at bit (i mod 4)*8. Each register reads back what was last written to it.
- R3: Offset 2+2k is the base register and offset 3+2k the limit register of region (region-number with its low two bits cleared) + k, for k in 0..3. Reads use the same mapping.
- R4: A region matches when its limit bit 0 (enable) is set and address bits [31:5] lie within base bits [31:5] and limit bits [31:5], both ends included.
- R5: The permission code sits in base bits [2:1]. Code 0 allows privileged reads and writes only, code 1 allows all reads and writes, code 2 allows privileged reads only, and code 3 allows reads from all.
- R6: A fetch that hits a region with base bit 0 (execute-never) set faults. A privileged fetch that hits a region with limit bit 4 (privileged-execute-never) set faults.
- R7: When the address matches two or more enabled regions, the access faults with `rsp_hit` 0.
- R8: When no enabled region matches, a privileged access is permitted if control bit 2 is set. Every other miss faults, and `rsp_hit` is 0.
- R9: On a single match, `rsp_hit` is 1, `rsp_region` gives the region number, and `rsp_attr` gives the table entry selected by limit bits [3:1], whether or not the access is permitted. Without a single match, `rsp_region` and `rsp_attr` are 0.
- R10: Each lookup request produces exactly one response, with `rsp_valid` high in the cycle after `lk_valid`. The response is computed from the register contents at the time of the request.
- R11: While control bit 0 is clear, every lookup is permitted with `rsp_hit` 0 and `rsp_attr` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational on cfg_addr |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup address |
| lk_priv | input | 1 | Access is privileged |
| lk_write | input | 1 | Access is a write |
| lk_fetch | input | 1 | Access is an instruction fetch |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_permit | output | 1 | Access permitted |
| rsp_hit | output | 1 | Exactly one region matched |
| rsp_region | output | 3 | Matched region number |
| rsp_attr | output | 8 | Attribute byte of the matched region |

## Verification
The properties assume that the lookup qualifiers are driven to known values whenever `lk_valid` is high. They also assume that the response reflects the register contents of the request cycle, so a write landing in that same cycle does not take effect until the next request. The stimulus respects both assumptions: lookups never coincide with register writes, and the qualifiers are always driven. Regions are drawn from a narrow address window so that hits, overlaps, empty ranges and misses all appear often.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  localparam int DW          = 32;
  localparam int FLD_W       = 5;
  localparam int ATTR_IDX_W  = 3;
  localparam int ATTR_ENTRIES = 1 << ATTR_IDX_W;
  localparam int ATTR_REGS   = ATTR_ENTRIES / 4;
  localparam int ALIAS_PAIRS = 4;

  // register word offsets
  localparam int OFS_CTRL  = 0;
  localparam int OFS_RNR   = 1;
  localparam int OFS_ALIAS = 2;
  localparam int OFS_ATTR  = OFS_ALIAS + 2 * ALIAS_PAIRS;
  localparam int CFG_AW    = $clog2(OFS_ATTR + ATTR_REGS);

  // control bits
  localparam int C_EN  = 0;
  localparam int C_DEF = 2;
  // limit low-field bit
  localparam int L_EN  = 0;

  typedef enum logic [1:0] {
    AP_PRIV_RW = 2'd0,
    AP_ALL_RW  = 2'd1,
    AP_PRIV_RO = 2'd2,
    AP_ALL_RO  = 2'd3
  } ap_e;

  typedef struct packed {
    logic                  xn;
    logic                  pxn;
    ap_e                   ap;
    logic [1:0]            sh;
    logic [ATTR_IDX_W-1:0] idx;
  } rgn_fld_t;

  function automatic rgn_fld_t unpack_fields(logic [FLD_W-1:0] b_lo, logic [FLD_W-1:0] l_lo);
    rgn_fld_t f;
    f.xn  = b_lo[0];
    f.ap  = ap_e'(b_lo[2:1]);
    f.sh  = b_lo[4:3];
    f.idx = l_lo[3:1];
    f.pxn = l_lo[4];
    return f;
  endfunction

  function automatic logic ap_allows(ap_e ap, logic priv, logic wr);
    case (ap)
      AP_PRIV_RW: return priv;
      AP_ALL_RW:  return 1'b1;
      AP_PRIV_RO: return priv & ~wr;
      default:    return ~wr;
    endcase
  endfunction

  function automatic logic [7:0] attr_entry(logic [ATTR_REGS-1:0][DW-1:0] tbl,
                                            logic [ATTR_IDX_W-1:0] i);
    return tbl[i[ATTR_IDX_W-1:2]][{i[1:0], 3'b000} +: 8];
  endfunction
endpackage

// File: rtl/bpu_regfile.sv
module bpu_regfile import bpu_pkg::*; #(
  parameter int NUM_REGIONS = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [CFG_AW-1:0]               cfg_addr,
  input  logic [DW-1:0]                   cfg_wdata,
  output logic [DW-1:0]                   cfg_rdata,
  output logic [2:0]                      ctrl_q,
  output logic [NUM_REGIONS-1:0][DW-1:0]  base_q,
  output logic [NUM_REGIONS-1:0][DW-1:0]  limit_q,
  output logic [ATTR_REGS-1:0][DW-1:0]    attr_q
);
  localparam int RW   = $clog2(NUM_REGIONS);
  localparam int AR_W = $clog2(ATTR_REGS);

  logic [RW-1:0]     rnr_q;
  logic [CFG_AW-1:0] a_rel, t_rel;
  logic              is_alias, is_attr, alias_lim;
  logic [RW-1:0]     alias_rgn;

  function automatic logic [RW-1:0] alias_target(logic [RW-1:0] rnr, logic [1:0] k);
    return (rnr & ~RW'(ALIAS_PAIRS - 1)) | RW'(k);
  endfunction

  always_comb begin
    a_rel     = cfg_addr - CFG_AW'(OFS_ALIAS);
    t_rel     = cfg_addr - CFG_AW'(OFS_ATTR);
    is_alias  = a_rel < CFG_AW'(2 * ALIAS_PAIRS);
    is_attr   = t_rel < CFG_AW'(ATTR_REGS);
    alias_lim = a_rel[0];
    alias_rgn = alias_target(rnr_q, a_rel[2:1]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      rnr_q   <= '0;
      base_q  <= '0;
      limit_q <= '0;
      attr_q  <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_AW'(OFS_CTRL))      ctrl_q <= cfg_wdata[2:0];
      else if (cfg_addr == CFG_AW'(OFS_RNR))  rnr_q  <= cfg_wdata[RW-1:0];
      else if (is_alias) begin
        if (alias_lim) limit_q[alias_rgn] <= cfg_wdata;
        else           base_q[alias_rgn]  <= cfg_wdata;
      end else if (is_attr) attr_q[t_rel[AR_W-1:0]] <= cfg_wdata;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == CFG_AW'(OFS_CTRL))      cfg_rdata = DW'(ctrl_q);
    else if (cfg_addr == CFG_AW'(OFS_RNR))  cfg_rdata = DW'(rnr_q);
    else if (is_alias) cfg_rdata = alias_lim ? limit_q[alias_rgn] : base_q[alias_rgn];
    else if (is_attr)  cfg_rdata = attr_q[t_rel[AR_W-1:0]];
  end
endmodule

// File: rtl/bpu_match.sv
module bpu_match #(
  parameter int NUM_REGIONS = 8,
  parameter int BW          = 27
) (
  input  logic [BW-1:0]                  blk,
  input  logic [NUM_REGIONS-1:0][BW-1:0] lo_blk,
  input  logic [NUM_REGIONS-1:0][BW-1:0] hi_blk,
  input  logic [NUM_REGIONS-1:0]         rgn_en,
  output logic [NUM_REGIONS-1:0]         hit_vec
);
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
    logic above_lo, below_hi;
    assign above_lo   = blk >= lo_blk[g];
    assign below_hi   = blk <= hi_blk[g];
    assign hit_vec[g] = rgn_en[g] & above_lo & below_hi;
  end
endmodule

// File: rtl/bpu_resolve.sv
module bpu_resolve import bpu_pkg::*; #(
  parameter int NUM_REGIONS = 8
) (
  input  logic [NUM_REGIONS-1:0]          hit_vec,
  input  rgn_fld_t [NUM_REGIONS-1:0]      rgn_fld,
  input  logic [ATTR_REGS-1:0][DW-1:0]    attr_q,
  input  logic                            unit_en,
  input  logic                            def_map,
  input  logic                            priv,
  input  logic                            wr,
  input  logic                            fetch,
  output logic                            permit,
  output logic                            hit,
  output logic [$clog2(NUM_REGIONS)-1:0]  region,
  output logic [7:0]                      attr,
  output logic                            hit_xn
);
  localparam int RW = $clog2(NUM_REGIONS);

  rgn_fld_t          sel;
  logic [RW-1:0]     sel_num;
  logic              single, multi;

  always_comb begin
    sel     = '0;
    sel_num = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hit_vec[i]) begin
        sel     = rgn_fld_t'(sel | rgn_fld[i]);
        sel_num = sel_num | RW'(i);
      end
    end
    single = $countones(hit_vec) == 1;
    multi  = $countones(hit_vec) > 1;
  end

  assign hit_xn = single & sel.xn;

  always_comb begin
    permit = 1'b0;
    hit    = 1'b0;
    region = '0;
    attr   = '0;
    if (!unit_en) begin
      permit = 1'b1;
    end else if (single) begin
      hit    = 1'b1;
      region = sel_num;
      attr   = attr_entry(attr_q, sel.idx);
      permit = ap_allows(sel.ap, priv, wr) & ~(fetch & sel.xn) & ~(fetch & priv & sel.pxn);
    end else if (!multi) begin
      permit = priv & def_map;
    end
  end
endmodule

// File: rtl/region_guard.sv
module region_guard import bpu_pkg::*; #(
  parameter int NUM_REGIONS = 8,
  parameter int GRAN_LG     = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [CFG_AW-1:0]               cfg_addr,
  input  logic [DW-1:0]                   cfg_wdata,
  output logic [DW-1:0]                   cfg_rdata,
  input  logic                            lk_valid,
  input  logic [DW-1:0]                   lk_addr,
  input  logic                            lk_priv,
  input  logic                            lk_write,
  input  logic                            lk_fetch,
  output logic                            rsp_valid,
  output logic                            rsp_permit,
  output logic                            rsp_hit,
  output logic [$clog2(NUM_REGIONS)-1:0]  rsp_region,
  output logic [7:0]                      rsp_attr
);
  localparam int RW = $clog2(NUM_REGIONS);
  localparam int BW = DW - GRAN_LG;

  logic [2:0]                      ctrl_q;
  logic [NUM_REGIONS-1:0][DW-1:0]  base_q, limit_q;
  logic [ATTR_REGS-1:0][DW-1:0]    attr_q;

  bpu_regfile #(.NUM_REGIONS(NUM_REGIONS)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ctrl_q(ctrl_q),
    .base_q(base_q), .limit_q(limit_q), .attr_q(attr_q)
  );

  logic [NUM_REGIONS-1:0][BW-1:0] lo_blk, hi_blk;
  logic [NUM_REGIONS-1:0]         rgn_en;
  rgn_fld_t [NUM_REGIONS-1:0]     rgn_fld;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_unpack
    assign lo_blk[g]  = base_q[g][DW-1:GRAN_LG];
    assign hi_blk[g]  = limit_q[g][DW-1:GRAN_LG];
    assign rgn_en[g]  = limit_q[g][L_EN];
    assign rgn_fld[g] = unpack_fields(base_q[g][FLD_W-1:0], limit_q[g][FLD_W-1:0]);
  end

  // named internal events for the checker
  logic [NUM_REGIONS-1:0] hit_vec;
  logic                   hit_xn;
  logic                   unit_en, def_map;
  assign unit_en = ctrl_q[C_EN];
  assign def_map = ctrl_q[C_DEF];

  bpu_match #(.NUM_REGIONS(NUM_REGIONS), .BW(BW)) match_i (
    .blk(lk_addr[DW-1:GRAN_LG]), .lo_blk(lo_blk), .hi_blk(hi_blk),
    .rgn_en(rgn_en), .hit_vec(hit_vec)
  );

  logic          nx_permit, nx_hit;
  logic [RW-1:0] nx_region;
  logic [7:0]    nx_attr;

  bpu_resolve #(.NUM_REGIONS(NUM_REGIONS)) resolve_i (
    .hit_vec(hit_vec), .rgn_fld(rgn_fld), .attr_q(attr_q),
    .unit_en(unit_en), .def_map(def_map),
    .priv(lk_priv), .wr(lk_write), .fetch(lk_fetch),
    .permit(nx_permit), .hit(nx_hit), .region(nx_region), .attr(nx_attr),
    .hit_xn(hit_xn)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_permit <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_region <= '0;
      rsp_attr   <= '0;
    end else begin
      rsp_valid  <= lk_valid;
      rsp_permit <= nx_permit;
      rsp_hit    <= nx_hit;
      rsp_region <= nx_region;
      rsp_attr   <= nx_attr;
    end
  end
endmodule

// File: rtl/region_guard_chk.sv
module region_guard_chk #(
  parameter int NUM_REGIONS = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   lk_valid,
  input logic                   lk_priv,
  input logic                   lk_fetch,
  input logic                   rsp_valid,
  input logic                   rsp_permit,
  input logic                   rsp_hit,
  input logic [7:0]             rsp_attr,
  input logic                   unit_en,
  input logic                   def_map,
  input logic [NUM_REGIONS-1:0] hit_vec,
  input logic                   hit_xn
);
  assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  assert_off_permits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !unit_en |=> rsp_permit && !rsp_hit && rsp_attr == 8'h00);
  assert_overlap_faults_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && unit_en && $countones(hit_vec) > 1 |=> !rsp_permit && !rsp_hit);
  assert_miss_user_faults_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && unit_en && hit_vec == '0 && !lk_priv |=> !rsp_permit && !rsp_hit);
  assert_miss_priv_default_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && unit_en && hit_vec == '0 && lk_priv |=> rsp_permit == $past(def_map));
  assert_xn_fetch_faults_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && unit_en && lk_fetch && hit_xn |=> !rsp_permit && rsp_hit);
  assert_nohit_attr_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_attr == 8'h00);
endmodule

bind region_guard region_guard_chk #(.NUM_REGIONS(NUM_REGIONS)) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_priv(lk_priv),
  .lk_fetch(lk_fetch), .rsp_valid(rsp_valid), .rsp_permit(rsp_permit),
  .rsp_hit(rsp_hit), .rsp_attr(rsp_attr), .unit_en(unit_en),
  .def_map(def_map), .hit_vec(hit_vec), .hit_xn(hit_xn)
);

// File: tb/region_guard_tb_top.sv
`timescale 1ns/1ps
module region_guard_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, cfg_we, lk_valid, lk_priv, lk_write, lk_fetch;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata, lk_addr;
  logic        rsp_valid, rsp_permit, rsp_hit;
  logic [2:0]  rsp_region;
  logic [7:0]  rsp_attr;

  region_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .lk_priv(lk_priv), .lk_write(lk_write), .lk_fetch(lk_fetch),
    .rsp_valid(rsp_valid), .rsp_permit(rsp_permit), .rsp_hit(rsp_hit),
    .rsp_region(rsp_region), .rsp_attr(rsp_attr)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // bench-side register model
  logic [31:0] m_base [8];
  logic [31:0] m_limit[8];
  logic [31:0] m_attr [2];
  logic [2:0]  m_ctrl;
  logic [2:0]  m_rnr;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int alias_region(input int off);
    return (int'(m_rnr) / 4) * 4 + (off - 2) / 2;
  endfunction

  function automatic logic [31:0] exp_read(input int off);
    if (off == 0) return {29'd0, m_ctrl};
    if (off == 1) return {29'd0, m_rnr};
    if (off >= 2 && off <= 9)
      return ((off - 2) % 2 == 0) ? m_base[alias_region(off)] : m_limit[alias_region(off)];
    if (off == 10 || off == 11) return m_attr[off - 10];
    return 32'd0;
  endfunction

  // {permit, hit, region[2:0], attr[7:0]}
  function automatic logic [12:0] exp_lookup(input logic [31:0] a, input bit p, input bit w, input bit f);
    int cnt = 0;
    int which = 0;
    bit ok;
    int idx;
    logic [7:0] at;
    for (int r = 0; r < 8; r++) begin
      if (m_limit[r][0] && (a >> 5) >= (m_base[r] >> 5) && (a >> 5) <= (m_limit[r] >> 5)) begin
        cnt++;
        which = r;
      end
    end
    if (!m_ctrl[0]) return {1'b1, 1'b0, 3'd0, 8'd0};
    if (cnt == 0)   return {p & m_ctrl[2], 1'b0, 3'd0, 8'd0};
    if (cnt > 1)    return 13'd0;
    case (m_base[which][2:1])
      2'd0: ok = p;
      2'd1: ok = 1'b1;
      2'd2: ok = p && !w;
      default: ok = !w;
    endcase
    if (f && m_base[which][0]) ok = 1'b0;
    if (f && p && m_limit[which][4]) ok = 1'b0;
    idx = int'(m_limit[which][3:1]);
    at  = 8'((m_attr[idx / 4] >> (8 * (idx % 4))) & 32'hFF);
    return {ok, 1'b1, 3'(which), at};
  endfunction

  task automatic wr(input int off, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(off); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (off == 0) m_ctrl = d[2:0];
    else if (off == 1) m_rnr = d[2:0];
    else if (off >= 2 && off <= 9) begin
      if ((off - 2) % 2 == 0) m_base[alias_region(off)]  = d;
      else                    m_limit[alias_region(off)] = d;
    end else if (off == 10 || off == 11) m_attr[off - 10] = d;
  endtask

  task automatic rd_chk(input int off, input string tag);
    logic [31:0] e;
    @(negedge clk);
    cfg_addr = 4'(off);
    #1;
    e = exp_read(off);
    check(cfg_rdata === e, tag, 64'(cfg_rdata), 64'(e));
  endtask

  task automatic set_region(input int r, input logic [31:0] b, input logic [31:0] l);
    wr(1, 32'(r));
    wr(2 + 2 * (r % 4), b);
    wr(3 + 2 * (r % 4), l);
  endtask

  task automatic look(input logic [31:0] a, input bit p, input bit w, input bit f, input string tag);
    logic [12:0] e;
    logic [13:0] act;
    e = exp_lookup(a, p, w, f);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; lk_priv = p; lk_write = w; lk_fetch = f;
    @(negedge clk);
    lk_valid = 1'b0;
    act = {rsp_valid, rsp_permit, rsp_hit, rsp_region, rsp_attr};
    check(act === {1'b1, e}, tag, 64'(act), 64'({1'b1, e}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin m_base[i] = '0; m_limit[i] = '0; end
    m_attr[0] = '0; m_attr[1] = '0; m_ctrl = '0; m_rnr = '0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    lk_valid = 1'b0; lk_addr = '0; lk_priv = 1'b0; lk_write = 1'b0; lk_fetch = 1'b0;
    repeat (3) @(negedge clk);
    check(rsp_valid === 1'b0 && rsp_permit === 1'b0, "R1 reset outputs",
          64'({rsp_valid, rsp_permit}), 64'd0);
    rst_n = 1'b1;
    for (int off = 0; off < 12; off++) rd_chk(off, "R1 register reset value");
    look(32'h0000_1234, 1'b0, 1'b1, 1'b0, "R1 disabled after reset permits");

    // R2 register map
    wr(0, 32'hFFFF_FFFF); rd_chk(0, "R2 control keeps three bits");
    wr(1, 32'hFFFF_FFFD); rd_chk(1, "R2 region number masked");
    wr(10, 32'h4433_2211); rd_chk(10, "R2 attribute word 0");
    wr(11, 32'h8877_6655); rd_chk(11, "R2 attribute word 1");
    wr(0, 32'h0000_0001);

    // R3 alias addressing: rnr=5, alias 2 base -> region 6
    wr(1, 32'd5);
    wr(6, 32'h00AB_CDE0);
    check(m_base[6] == 32'h00AB_CDE0, "R3 bench alias map", 64'(m_base[6]), 64'h00AB_CDE0);
    wr(1, 32'd0); rd_chk(6, "R3 alias 2 in group 0 reads region 2");
    wr(1, 32'd7); rd_chk(6, "R3 alias 2 in group 4 reads region 6");
    wr(1, 32'd6); rd_chk(7, "R3 alias 2 limit in group 4");
    set_region(6, 32'h0, 32'h0);

    // R4 inclusive block bounds on region 3
    set_region(3, 32'h0000_0102, 32'h0000_01E1);
    look(32'h0000_0100, 1'b0, 1'b0, 1'b0, "R4 first byte of first block");
    look(32'h0000_01FF, 1'b0, 1'b1, 1'b0, "R4 last byte of last block");
    look(32'h0000_00FF, 1'b0, 1'b0, 1'b0, "R4 byte below range misses");
    look(32'h0000_0200, 1'b0, 1'b0, 1'b0, "R4 byte above range misses");
    set_region(3, 32'h0000_0102, 32'h0000_01E0);
    look(32'h0000_0140, 1'b1, 1'b0, 1'b0, "R4 disabled region ignored");

    // R5 permission codes
    for (int ap = 0; ap < 4; ap++) begin
      set_region(3, 32'h0000_0100 | 32'(ap << 1), 32'h0000_01E1);
      for (int pw = 0; pw < 4; pw++)
        look(32'h0000_0180, pw[1], pw[0], 1'b0, "R5 permission code");
    end

    // R6 execute-never and privileged execute-never
    set_region(3, 32'h0000_0103, 32'h0000_01E1);
    look(32'h0000_0120, 1'b0, 1'b0, 1'b1, "R6 xn user fetch");
    look(32'h0000_0120, 1'b1, 1'b0, 1'b1, "R6 xn priv fetch");
    look(32'h0000_0120, 1'b0, 1'b0, 1'b0, "R6 xn read allowed");
    set_region(3, 32'h0000_0102, 32'h0000_01F1);
    look(32'h0000_0120, 1'b1, 1'b0, 1'b1, "R6 pxn priv fetch");
    look(32'h0000_0120, 1'b0, 1'b0, 1'b1, "R6 pxn user fetch allowed");

    // R7 overlap
    set_region(4, 32'h0000_0182, 32'h0000_02E1);
    look(32'h0000_01A0, 1'b1, 1'b0, 1'b0, "R7 overlap faults");
    look(32'h0000_0220, 1'b0, 1'b0, 1'b0, "R7 single side hits region 4");

    // R8 misses and the default map
    wr(0, 32'd5);
    look(32'h0000_5000, 1'b1, 1'b1, 1'b0, "R8 priv miss with default map");
    look(32'h0000_5000, 1'b0, 1'b0, 1'b0, "R8 user miss faults");
    wr(0, 32'd1);
    look(32'h0000_5000, 1'b1, 1'b0, 1'b0, "R8 priv miss without default map");

    // R9 attribute selection for every index
    for (int ix = 0; ix < 8; ix++) begin
      set_region(3, 32'h0000_0100, 32'h0000_01E1 | 32'(ix << 1));
      look(32'h0000_0110, 1'b0, 1'b1, 1'b0, "R9 attribute entry by index");
    end

    // R10 one response per request
    look(32'h0000_0110, 1'b1, 1'b0, 1'b0, "R10 response one cycle later");
    @(negedge clk);
    check(rsp_valid === 1'b0, "R10 single response", 64'(rsp_valid), 64'd0);

    // R11 unit disabled
    wr(0, 32'd4);
    look(32'h0000_01A0, 1'b0, 1'b1, 1'b1, "R11 disabled permits overlap address");
    look(32'h0000_0110, 1'b0, 1'b1, 1'b0, "R11 disabled ignores region");

    // constrained random rounds
    for (int rnd = 0; rnd < 40; rnd++) begin
      wr(0, ($urandom % 6 == 0) ? 32'($urandom % 8 & 6) : 32'(($urandom % 8) | 1));
      wr(10, $urandom);
      wr(11, $urandom);
      for (int r = 0; r < 8; r++) begin
        int bb = $urandom % 64;
        int lb = bb + ($urandom % 12);
        if (bb > 0 && $urandom % 10 == 0) lb = bb - 1;
        set_region(r, 32'(bb << 5) | ($urandom & 32'h1F),
                   32'(lb << 5) | ($urandom & 32'h1E) | 32'($urandom % 4 != 0));
      end
      rd_chk($urandom % 12, "R2 random readback");
      for (int q = 0; q < 30; q++) begin
        logic [31:0] a = 32'($urandom % (80 * 32));
        if ($urandom % 16 == 0) a = a | 32'h8000_0000;
        look(a, 1'($urandom), 1'($urandom), 1'($urandom), "R4 R5 R6 R7 R8 R9 random lookup");
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule